// File: doc/BRIEF.md
# Context-Memory Loop Sequencer

This block steps through a small local program memory and issues one instruction per clock. Each instruction carries three control words: one for a register file, one for a datapath unit and one for the interconnect switches. All three go out together, qualified by a single valid strobe. Program flow is sequential by default. Two branch opcodes test a condition flag input. A pair of loop opcodes uses a two-level hardware counter stack, so loop bodies repeat without any compare-and-branch overhead.

Software loads the program through a configuration write port while the sequencer is idle. A start pulse then begins execution at address 0. A halt instruction ends the run: it pulses done and returns the sequencer to idle, ready for the next start. The controlled units themselves lie outside this block.

Top module: `ctx_seq`

## Requirements
- R1: While reset is held and right after it is released, ctrl_valid, done and all three control words are 0, and nothing executes until start is seen.
- R2: A configuration write stores cfg_data at cfg_addr only while the sequencer is idle. A write presented while a program runs is ignored, so the running program later fetches the old word.
- R3: A start seen while idle begins execution at address 0. The control words of address 0 appear on the outputs after the second rising edge that follows start being sampled. A start seen while running has no effect.
- R4: An instruction word is laid out from the top bit down as opcode (3 bits), target address, loop count, register-file word, datapath word and switch word, with the switch word in the low bits. Opcode 0 (plain) drives its three words with ctrl_valid high for one cycle and moves to the next address. One instruction executes per cycle.
- R5: Opcode 1 jumps to the target when cond is 1 and opcode 2 jumps when cond is 0; otherwise the next address follows. Both still issue their control words.
- R6: Opcode 3 (loop open) issues its words and pushes its count together with the address after it. Opcode 4 (loop close) issues its words. If the top count is above 1, it decrements the count and jumps back to the stored address; otherwise it pops and falls through. A body therefore runs max(count,1) times.
- R7: Two loop levels nest. A loop open with both levels in use pushes nothing, and a loop close with no level in use falls through.
- R8: Opcode 5 (halt) issues no control words, drives done high for exactly one cycle and returns the sequencer to idle.
- R9: Opcodes 6 and 7 behave exactly like opcode 0.
- R10: A configuration write presented in the same cycle as an accepted start is stored before the first fetch, so a write to address 0 is the first instruction executed.
- R11: After the last address, the program address wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 when idle |
| cond | input | 1 | Status flag tested by branch opcodes |
| cfg_we | input | 1 | Program memory write enable |
| cfg_addr | input | ADDR_W (4) | Program memory write address |
| cfg_data | input | INS_W (43) | Instruction word to store |
| rf_ctrl | output | RF_W (12) | Register-file control word |
| dpu_ctrl | output | DPU_W (10) | Datapath control word |
| sw_ctrl | output | SW_W (8) | Interconnect switch control word |
| ctrl_valid | output | 1 | Control words are valid this cycle |
| done | output | 1 | One-cycle pulse when a halt executes |

## Verification
Two functions can meet in the same edge: a configuration write and the start that launches a program. The same applies to a write or start that arrives while the program is running. The bench provokes these cases in directed runs, such as a write to address 0 in the start cycle or a write and a restart partway through a run. Random runs also scatter writes and starts over every cycle. A bench-side program model decides whether each write lands or is ignored and whether each start is taken. It then checks every issued control word, done pulse and loop exit against that model, cycle by cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_PLAIN  = 3'd0,
      OP_JMP_HI = 3'd1,
      OP_JMP_LO = 3'd2,
      OP_LOPEN  = 3'd3,
      OP_LCLOSE = 3'd4,
      OP_STOP   = 3'd5,
      OP_SPARE6 = 3'd6,
      OP_SPARE7 = 3'd7
   } seq_op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;

endpackage

// File: rtl/ctx_mem.sv
module ctx_mem #(
   parameter int DEPTH = 16,
   parameter int W     = 43,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy_i,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];

   // R2: program words cannot change under a running program
   property p_frozen_while_busy;
      @(posedge clk) disable iff (!rst_n)
         (busy_i && $past(busy_i) && raddr == $past(raddr)) |-> (rdata == $past(rdata));
   endproperty
   assert_frozen_while_busy_R2: assert property (p_frozen_while_busy);

endmodule

// File: rtl/loop_stack.sv
module loop_stack #(
   parameter int NEST   = 2,
   parameter int CNT_W  = 6,
   parameter int ADDR_W = 4,
   localparam int DW    = $clog2(NEST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [CNT_W-1:0]  push_cnt,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              dec,
   input  logic              pop,
   output logic [CNT_W-1:0]  top_cnt,
   output logic [ADDR_W-1:0] top_addr,
   output logic              empty,
   output logic              full
);

   logic [DW-1:0]     depth_q;
   logic [CNT_W-1:0]  cnt_q [NEST];
   logic [ADDR_W-1:0] adr_q [NEST];
   logic              push_ok;

   assign empty   = (depth_q == '0);
   assign full    = (depth_q == DW'(NEST));
   assign push_ok = push && !full && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n)                depth_q <= '0;
      else if (clr)              depth_q <= '0;
      else if (push_ok)          depth_q <= depth_q + DW'(1);
      else if (pop && !empty)    depth_q <= depth_q - DW'(1);
   end

   generate
      for (genvar gi = 0; gi < NEST; gi++) begin : g_level
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q[gi] <= '0;
               adr_q[gi] <= '0;
            end else if (push_ok && depth_q == DW'(gi)) begin
               cnt_q[gi] <= push_cnt;
               adr_q[gi] <= push_addr;
            end else if (dec && !clr && depth_q == DW'(gi + 1)) begin
               cnt_q[gi] <= cnt_q[gi] - CNT_W'(1);
            end
         end
      end
   endgenerate

   always_comb begin
      top_cnt  = '0;
      top_addr = '0;
      for (int i = 0; i < NEST; i++) begin
         if (depth_q == DW'(i + 1)) begin
            top_cnt  = cnt_q[i];
            top_addr = adr_q[i];
         end
      end
   end

   // R6: an accepted push adds exactly one level
   property p_push_grows;
      @(posedge clk) disable iff (!rst_n)
         (push && !full && !clr) |=> (depth_q == $past(depth_q) + DW'(1));
   endproperty
   assert_push_grows_R6: assert property (p_push_grows);

   // R6: a decrement leaves the level count alone and lowers the top count
   property p_dec_in_place;
      @(posedge clk) disable iff (!rst_n)
         (dec && !clr && !empty) |=> (depth_q == $past(depth_q)) && (top_cnt == $past(top_cnt) - CNT_W'(1));
   endproperty
   assert_dec_in_place_R6: assert property (p_dec_in_place);

   // R7: a push into a full stack is dropped
   property p_full_drop;
      @(posedge clk) disable iff (!rst_n)
         (push && full && !clr) |=> (depth_q == $past(depth_q));
   endproperty
   assert_full_drop_R7: assert property (p_full_drop);

endmodule

// File: rtl/seq_decode.sv
module seq_decode
   import seq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 6
) (
   input  logic              running,
   input  seq_op_e           op,
   input  logic              cond,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] tgt,
   input  logic              stk_empty,
   input  logic [CNT_W-1:0]  top_cnt,
   input  logic [ADDR_W-1:0] top_addr,
   output logic [ADDR_W-1:0] nxt_pc,
   output logic [ADDR_W-1:0] seq_pc,
   output logic              issue,
   output logic              halt,
   output logic              push,
   output logic              dec,
   output logic              pop
);

   assign seq_pc = pc + ADDR_W'(1);

   always_comb begin
      nxt_pc = seq_pc;
      issue  = 1'b0;
      halt   = 1'b0;
      push   = 1'b0;
      dec    = 1'b0;
      pop    = 1'b0;
      if (running) begin
         issue = (op != OP_STOP);
         unique case (op)
            OP_JMP_HI: if (cond)  nxt_pc = tgt;
            OP_JMP_LO: if (!cond) nxt_pc = tgt;
            OP_LOPEN:  push = 1'b1;
            OP_LCLOSE: begin
               if (!stk_empty) begin
                  if (top_cnt <= CNT_W'(1)) begin
                     pop = 1'b1;
                  end else begin
                     dec    = 1'b1;
                     nxt_pc = top_addr;
                  end
               end
            end
            OP_STOP:   halt = 1'b1;
            default:   nxt_pc = seq_pc;
         endcase
      end
   end

endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
   import seq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int RF_W   = 12,
   parameter int DPU_W  = 10,
   parameter int SW_W   = 8,
   parameter int CNT_W  = 6,
   parameter int NEST   = 2,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int SW_LO  = 0,
   localparam int DPU_LO = SW_LO + SW_W,
   localparam int RF_LO  = DPU_LO + DPU_W,
   localparam int CNT_LO = RF_LO + RF_W,
   localparam int TGT_LO = CNT_LO + CNT_W,
   localparam int OP_LO  = TGT_LO + ADDR_W,
   localparam int INS_W  = OP_LO + OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cond,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [INS_W-1:0]  cfg_data,
   output logic [RF_W-1:0]   rf_ctrl,
   output logic [DPU_W-1:0]  dpu_ctrl,
   output logic [SW_W-1:0]   sw_ctrl,
   output logic              ctrl_valid,
   output logic              done
);

   generate
      if (DEPTH < 2 || DEPTH != (1 << ADDR_W)) begin : g_bad_depth
         $error("ctx_seq: DEPTH must be a power of two of at least 2");
      end
      if (NEST < 1) begin : g_bad_nest
         $error("ctx_seq: NEST must be at least 1");
      end
      if (CNT_W < 1 || RF_W < 1 || DPU_W < 1 || SW_W < 1) begin : g_bad_width
         $error("ctx_seq: field widths must be positive");
      end
   endgenerate

   seq_state_e        state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [INS_W-1:0]  ins;
   seq_op_e           op;
   logic              running;
   logic              mem_we;

   logic [ADDR_W-1:0] nxt_pc, seq_pc, top_addr;
   logic [CNT_W-1:0]  top_cnt;
   logic              issue, halt, push, dec, pop, stk_empty, stk_full;

   assign running = (state_q == ST_RUN);
   assign mem_we  = cfg_we && !running;
   assign op      = seq_op_e'(ins[OP_LO +: OP_W]);

   ctx_mem #(.DEPTH(DEPTH), .W(INS_W)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (running),
      .we     (mem_we),
      .waddr  (cfg_addr),
      .wdata  (cfg_data),
      .raddr  (pc_q),
      .rdata  (ins)
   );

   seq_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
      .running   (running),
      .op        (op),
      .cond      (cond),
      .pc        (pc_q),
      .tgt       (ins[TGT_LO +: ADDR_W]),
      .stk_empty (stk_empty),
      .top_cnt   (top_cnt),
      .top_addr  (top_addr),
      .nxt_pc    (nxt_pc),
      .seq_pc    (seq_pc),
      .issue     (issue),
      .halt      (halt),
      .push      (push),
      .dec       (dec),
      .pop       (pop)
   );

   loop_stack #(.NEST(NEST), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (!running),
      .push      (push),
      .push_cnt  (ins[CNT_LO +: CNT_W]),
      .push_addr (seq_pc),
      .dec       (dec),
      .pop       (pop),
      .top_cnt   (top_cnt),
      .top_addr  (top_addr),
      .empty     (stk_empty),
      .full      (stk_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         pc_q       <= '0;
         rf_ctrl    <= '0;
         dpu_ctrl   <= '0;
         sw_ctrl    <= '0;
         ctrl_valid <= 1'b0;
         done       <= 1'b0;
      end else begin
         ctrl_valid <= issue;
         done       <= halt;
         rf_ctrl    <= issue ? ins[RF_LO +: RF_W]   : '0;
         dpu_ctrl   <= issue ? ins[DPU_LO +: DPU_W] : '0;
         sw_ctrl    <= issue ? ins[SW_LO +: SW_W]   : '0;
         if (!running) begin
            if (start) begin
               state_q <= ST_RUN;
               pc_q    <= '0;
            end
         end else if (halt) begin
            state_q <= ST_IDLE;
         end else begin
            pc_q <= nxt_pc;
         end
      end
   end

   // R8: done lasts one cycle
   property p_done_pulse;
      @(posedge clk) disable iff (!rst_n) done |=> !done;
   endproperty
   assert_done_pulse_R8: assert property (p_done_pulse);

   // R8: after a halt no control word follows in the next cycle
   property p_halt_quiet;
      @(posedge clk) disable iff (!rst_n) done |=> !ctrl_valid;
   endproperty
   assert_halt_quiet_R8: assert property (p_halt_quiet);

   // R8: a halt never issues words
   property p_excl;
      @(posedge clk) disable iff (!rst_n) !(done && ctrl_valid);
   endproperty
   assert_excl_R8: assert property (p_excl);

   // R3: issued words only come from a running sequencer
   property p_valid_from_run;
      @(posedge clk) disable iff (!rst_n) ctrl_valid |-> $past(running);
   endproperty
   assert_valid_from_run_R3: assert property (p_valid_from_run);

   // R1: idle words are zero
   property p_idle_zero;
      @(posedge clk) disable iff (!rst_n)
         !ctrl_valid |-> (rf_ctrl == '0 && dpu_ctrl == '0 && sw_ctrl == '0);
   endproperty
   assert_idle_zero_R1: assert property (p_idle_zero);

   // R7: a loop open into a full stack leaves the top count unchanged
   property p_full_keep;
      @(posedge clk) disable iff (!rst_n)
         (push && stk_full) |=> (top_cnt == $past(top_cnt));
   endproperty
   assert_full_keep_R7: assert property (p_full_keep);

endmodule

// File: tb/ctx_seq_bench.sv
module ctx_seq_bench;

   localparam int DEPTH  = 16;
   localparam int RF_W   = 12;
   localparam int DPU_W  = 10;
   localparam int SW_W   = 8;
   localparam int CNT_W  = 6;
   localparam int NEST   = 2;
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int SW_LO  = 0;
   localparam int DPU_LO = SW_LO + SW_W;
   localparam int RF_LO  = DPU_LO + DPU_W;
   localparam int CNT_LO = RF_LO + RF_W;
   localparam int TGT_LO = CNT_LO + CNT_W;
   localparam int OP_LO  = TGT_LO + ADDR_W;
   localparam int INS_W  = OP_LO + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, cond = 1'b0, cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [INS_W-1:0]  cfg_data = '0;
   logic [RF_W-1:0]   rf_ctrl;
   logic [DPU_W-1:0]  dpu_ctrl;
   logic [SW_W-1:0]   sw_ctrl;
   logic              ctrl_valid, done;

   always #5 clk = ~clk;

   ctx_seq u_ctx_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cond(cond),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .rf_ctrl(rf_ctrl), .dpu_ctrl(dpu_ctrl), .sw_ctrl(sw_ctrl),
      .ctrl_valid(ctrl_valid), .done(done)
   );

   int checks = 0;
   int fails  = 0;

   logic [INS_W-1:0] mm [DEPTH];
   bit   m_run = 0;
   int   m_pc = 0, m_sp = 0;
   int   m_cnt [NEST];
   int   m_adr [NEST];
   bit   e_valid, e_done;
   int   e_rf, e_dpu, e_sw;
   string e_tag;

   function automatic logic [INS_W-1:0] mk(int op, int tgt, int cnt, int rf, int dpu, int sw);
      logic [INS_W-1:0] w;
      w = '0;
      w[OP_LO +: 3]       = 3'(op);
      w[TGT_LO +: ADDR_W] = ADDR_W'(tgt);
      w[CNT_LO +: CNT_W]  = CNT_W'(cnt);
      w[RF_LO +: RF_W]    = RF_W'(rf);
      w[DPU_LO +: DPU_W]  = DPU_W'(dpu);
      w[SW_LO +: SW_W]    = SW_W'(sw);
      return w;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Program model built from the requirements.
   task automatic model(bit st, bit we, int a, logic [INS_W-1:0] d, bit c);
      logic [INS_W-1:0] w;
      int op, nx;
      e_valid = 0; e_done = 0; e_rf = 0; e_dpu = 0; e_sw = 0;
      if (!m_run) begin
         e_tag = "R2";
         if (we) mm[a] = d;
         if (st) begin
            m_run = 1; m_pc = 0; m_sp = 0; e_tag = "R3";
         end
      end else begin
         w  = mm[m_pc];
         op = int'(w[OP_LO +: 3]);
         nx = (m_pc + 1) % DEPTH;
         if (op == 5) begin
            e_done = 1; m_run = 0; e_tag = "R8";
         end else begin
            e_valid = 1;
            e_rf  = int'(w[RF_LO +: RF_W]);
            e_dpu = int'(w[DPU_LO +: DPU_W]);
            e_sw  = int'(w[SW_LO +: SW_W]);
            case (op)
               1: begin e_tag = "R5"; m_pc = c ? int'(w[TGT_LO +: ADDR_W]) : nx; end
               2: begin e_tag = "R5"; m_pc = !c ? int'(w[TGT_LO +: ADDR_W]) : nx; end
               3: begin
                  e_tag = "R6";
                  if (m_sp < NEST) begin
                     m_cnt[m_sp] = int'(w[CNT_LO +: CNT_W]);
                     m_adr[m_sp] = nx;
                     m_sp++;
                  end else e_tag = "R7";
                  m_pc = nx;
               end
               4: begin
                  e_tag = "R6";
                  if (m_sp == 0) begin e_tag = "R7"; m_pc = nx; end
                  else if (m_cnt[m_sp-1] <= 1) begin m_sp--; m_pc = nx; end
                  else begin m_cnt[m_sp-1]--; m_pc = m_adr[m_sp-1]; end
               end
               6, 7: begin e_tag = "R9"; m_pc = nx; end
               default: begin e_tag = "R4"; m_pc = nx; end
            endcase
         end
      end
   endtask

   // One clock: drive at a falling edge, check at the next falling edge.
   task automatic cyc(bit st, bit we, int a, logic [INS_W-1:0] d, bit c);
      start = st; cfg_we = we; cfg_addr = ADDR_W'(a); cfg_data = d; cond = c;
      model(st, we, a, d, c);
      @(negedge clk);
      chk(ctrl_valid == e_valid && done == e_done && int'(rf_ctrl) == e_rf &&
          int'(dpu_ctrl) == e_dpu && int'(sw_ctrl) == e_sw, e_tag,
          {ctrl_valid, done, 2'b0, rf_ctrl}, {e_valid, e_done, 2'b0, RF_W'(e_rf)});
      start = 0; cfg_we = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0);
   endtask

   task automatic do_reset();
      rst_n = 0; start = 0; cfg_we = 0;
      m_run = 0; m_sp = 0;
      repeat (3) @(negedge clk);
      chk(ctrl_valid == 0 && done == 0 && rf_ctrl == 0 && dpu_ctrl == 0 && sw_ctrl == 0,
          "R1", {ctrl_valid, done}, 0);
      rst_n = 1;
   endtask

   task automatic load(int a, logic [INS_W-1:0] d);
      cyc(0, 1, a, d, 0);
   endtask

   int vcount;
   int seq_rf [20];

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      do_reset();
      // R1: without start nothing runs
      idle(4);
      chk(ctrl_valid == 0 && done == 0, "R1", ctrl_valid, 0);

      // Directed: two nested loops, body counted by hand: 19 issued words.
      for (int i = 0; i < DEPTH; i++) load(i, mk(5, 0, 0, 0, 0, 0));
      load(0, mk(3, 0, 3, 1, 1, 1));
      load(1, mk(3, 0, 2, 2, 2, 2));
      load(2, mk(0, 0, 0, 3, 3, 3));
      load(3, mk(4, 0, 0, 4, 4, 4));
      load(4, mk(4, 0, 0, 5, 5, 5));
      cyc(1, 0, 0, '0, 0);
      vcount = 0;
      for (int i = 0; i < 40 && m_run; i++) begin
         cyc(0, 0, 0, '0, 0);
         if (ctrl_valid) vcount++;
      end
      chk(vcount == 19, "R6 nested count", vcount, 19);

      // Directed: third level dropped, close on empty falls through: 14 words.
      load(0, mk(3, 0, 2, 1, 0, 0));
      load(1, mk(3, 0, 2, 2, 0, 0));
      load(2, mk(3, 0, 2, 3, 0, 0));
      load(3, mk(4, 0, 0, 4, 0, 0));
      load(4, mk(4, 0, 0, 5, 0, 0));
      load(5, mk(4, 0, 0, 6, 0, 0));
      load(6, mk(5, 0, 0, 0, 0, 0));
      cyc(1, 0, 0, '0, 0);
      vcount = 0;
      for (int i = 0; i < 40 && m_run; i++) begin
         cyc(0, 0, 0, '0, 0);
         if (ctrl_valid) vcount++;
      end
      chk(vcount == 14, "R7 overflow count", vcount, 14);

      // Directed: branches with fixed cond.
      load(0, mk(1, 3, 0, 1, 0, 0));
      load(1, mk(5, 0, 0, 0, 0, 0));
      load(3, mk(2, 6, 0, 2, 0, 0));
      load(4, mk(6, 0, 0, 7, 0, 0));
      load(5, mk(7, 0, 0, 8, 0, 0));
      load(6, mk(5, 0, 0, 0, 0, 0));
      cyc(1, 0, 0, '0, 0);
      cyc(0, 0, 0, '0, 1);
      chk(rf_ctrl == 1, "R5 taken", int'(rf_ctrl), 1);
      cyc(0, 0, 0, '0, 1);
      chk(rf_ctrl == 2, "R5 at target", int'(rf_ctrl), 2);
      cyc(0, 0, 0, '0, 0);
      chk(rf_ctrl == 7, "R9 spare 6", int'(rf_ctrl), 7);
      cyc(0, 0, 0, '0, 0);
      chk(rf_ctrl == 8, "R9 spare 7", int'(rf_ctrl), 8);
      cyc(0, 0, 0, '0, 0);
      chk(done == 1 && ctrl_valid == 0, "R8 halt", done, 1);
      cyc(0, 0, 0, '0, 0);
      chk(done == 0, "R8 single pulse", done, 0);

      // Directed: write collides with start (R10).
      load(0, mk(0, 0, 0, 12'h111, 0, 0));
      load(1, mk(5, 0, 0, 0, 0, 0));
      cyc(1, 1, 0, mk(0, 0, 0, 12'hABC, 0, 0), 0);
      cyc(0, 0, 0, '0, 0);
      chk(rf_ctrl == 12'hABC, "R10 collision", int'(rf_ctrl), 12'hABC);
      idle(2);

      // Directed: wrap, write and restart while running.
      for (int i = 0; i < DEPTH; i++) load(i, mk(0, 0, 0, i, i, i));
      cyc(1, 0, 0, '0, 0);
      for (int i = 0; i < 18; i++) begin
         if (i == 2) cyc(0, 1, 5, mk(0, 0, 0, 12'h7FF, 0, 0), 0);
         else if (i == 8) cyc(1, 0, 0, '0, 0);
         else cyc(0, 0, 0, '0, 0);
         seq_rf[i] = int'(rf_ctrl);
      end
      chk(seq_rf[5] == 5, "R2 write ignored", seq_rf[5], 5);
      chk(seq_rf[9] == 9, "R3 restart ignored", seq_rf[9], 9);
      chk(seq_rf[15] == 15 && seq_rf[16] == 0 && seq_rf[17] == 1, "R11 wrap",
          seq_rf[16], 0);
      do_reset();
      chk(ctrl_valid == 0, "R1 reset mid-run", ctrl_valid, 0);
      idle(1);

      // Constrained random programs.
      for (int r = 0; r < 40; r++) begin
         do_reset();
         for (int a = 0; a < DEPTH; a++) begin
            int pick, op;
            pick = $urandom_range(99);
            op = pick < 40 ? 0 : pick < 50 ? 1 : pick < 60 ? 2 : pick < 74 ? 3 :
                 pick < 88 ? 4 : pick < 94 ? 5 : 6 + (pick % 2);
            load(a, mk(op, $urandom_range(DEPTH - 1), $urandom_range(3),
                       $urandom, $urandom, $urandom));
         end
         cyc(1, $urandom_range(2) == 0, 0,
             mk($urandom_range(4), $urandom_range(DEPTH - 1), 2, $urandom, $urandom, $urandom), 0);
         for (int i = 0; i < 300 && m_run; i++) begin
            cyc($urandom_range(19) == 0, $urandom_range(19) == 0,
                $urandom_range(DEPTH - 1),
                mk($urandom_range(7), $urandom_range(DEPTH - 1), $urandom_range(3),
                   $urandom, $urandom, $urandom),
                $urandom_range(1) == 1);
         end
         idle(2);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule